// File: doc/BRIEF.md
# Label Equivalence Table with Parallel Alias Rewrite

This block keeps the label aliases that one labeling processing element gathers while it scans an image row. Each stored entry pairs a label (the key) with the label it currently resolves to (the value). The labeling logic sends equivalence records of the form (old, new). The new label is always the smaller label that survives a merge. On each record, every entry whose value equals the old label is rewritten to the new label, and all entries are compared at once. A chain of aliases therefore collapses in one cycle, and no pointer walk is needed later. A pixel that opens a fresh component sends the self record (L, L), so that L gets an entry of its own.

Processing elements work in pairs, set by the `ODD_PE` parameter. An odd element passes each of its own records to the next element in the same cycle, and it ignores its own receive port. An even element applies two records in the same cycle: first its own, then the one received from its predecessor, and the second sees the result of the first. A combinational lookup returns the resolved label for a query. A label with no entry comes back unchanged.

A small controller tracks how full the table is, with four states. `S_EMPTY` means no entry is used, `S_PART` means some are, `S_FULL` means all are, and `S_OVF` means an allocation was lost. The transitions are:
- *fill*: `S_EMPTY` to `S_PART`, or straight to `S_FULL`, when entries are allocated.
- *top-up*: `S_PART` to `S_FULL` when the last free entry is taken.
- *spill*: `S_FULL` to `S_OVF` when a record needs an entry and none is free.
- *hold*: `S_OVF` stays in `S_OVF` until a clear.
- *wipe*: any state to `S_EMPTY` on `clr_i`, which is issued at the start of each row.

Top module: `label_equiv_table`

## Requirements
- R1: A self record (L, L) stores L with value L. Once a later record merges L into a smaller label M, a lookup of L returns M.
- R2: A record (o, n) rewrites to n every valid entry whose value equals o, all in the same clock edge, and leaves every other entry as it was. A lookup sees the new content from the cycle after the record.
- R3: `qry_res_o` depends combinationally on the stored content. For a label that has no valid entry it equals `qry_lbl_i`; otherwise it returns that entry's value.
- R4: A record whose old label is not a stored key allocates the lowest-indexed free entry, with key = old and value = new. A record whose old label is already a key allocates nothing. Keys are therefore never duplicated.
- R5: With `ODD_PE` = 0, when an own record and a received record arrive in the same cycle, the own record is applied first. The received record then acts on the table as the own record left it, including any entry the own record allocated.
- R6: With `ODD_PE` = 1, the received-record inputs have no effect, and the own record appears on `nxt_vld_o`/`nxt_old_o`/`nxt_new_o` in the same cycle. With `ODD_PE` = 0, `nxt_vld_o` stays 0.
- R7: `full_o` is 1 exactly when every entry is valid. A record that needs an allocation while the table is full loses that allocation but still performs its rewrite. It sets `ovf_o`, which stays 1 until a clear.
- R8: After a cycle with `clr_i` = 1, all entries are free and `full_o` and `ovf_o` are 0.
- R9: A clear takes precedence over records presented in the same cycle, which leave no entry behind.
- R10: After reset the table is empty and `full_o`, `ovf_o` and `nxt_vld_o` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear at the start of a row |
| own_vld_i | input | 1 | Own record valid |
| own_old_i | input | LW | Own record, old label |
| own_new_i | input | LW | Own record, new (smaller) label |
| prv_vld_i | input | 1 | Record from the previous element valid |
| prv_old_i | input | LW | Received record, old label |
| prv_new_i | input | LW | Received record, new label |
| qry_lbl_i | input | LW | Label to resolve |
| qry_res_o | output | LW | Resolved label |
| nxt_vld_o | output | 1 | Record passed to the next element valid |
| nxt_old_o | output | LW | Passed record, old label |
| nxt_new_o | output | LW | Passed record, new label |
| full_o | output | 1 | Every entry in use |
| ovf_o | output | 1 | Sticky overflow: an allocation was lost |

## Verification
The hardest situation to reach is two records in one cycle where the order of application changes the outcome. The received record must rewrite a value that the own record has only just produced, and it must also allocate the last free entry. The stimulus table first builds three aliased entries through self records and merges. It then issues the own record (9, 2) together with the received record (2, 1). Applying them in the right order resolves label 9 to 1, while the wrong order leaves it at 2, and the extra allocation is what fills the table. The full table is then used straight away to provoke a lost allocation whose rewrite still lands.

// File: rtl/eqt_pkg.sv
package eqt_pkg;

    // Occupancy states of the equivalence table
    typedef enum logic [1:0] {
        S_EMPTY = 2'd0,
        S_PART  = 2'd1,
        S_FULL  = 2'd2,
        S_OVF   = 2'd3
    } eqt_state_e;

endpackage

// File: rtl/eqt_update.sv
// One record applied to the whole entry array: parallel rewrite plus allocation.
module eqt_update #(
    parameter int N  = 16,
    parameter int LW = 8
) (
    input  logic [N-1:0]  vld_i,
    input  logic [LW-1:0] key_i [N],
    input  logic [LW-1:0] val_i [N],
    input  logic          rec_vld_i,
    input  logic [LW-1:0] rec_old_i,
    input  logic [LW-1:0] rec_new_i,
    output logic [N-1:0]  vld_o,
    output logic [LW-1:0] key_o [N],
    output logic [LW-1:0] val_o [N],
    output logic          drop_o
);

    logic [N-1:0] val_hit;
    logic [N-1:0] key_hit;
    logic [N-1:0] first_free;
    logic [N-1:0] alloc_here;
    logic         need_alloc;

    // Lowest free entry as a one-hot vector
    always_comb begin
        logic seen;
        seen = 1'b0;
        for (int i = 0; i < N; i++) begin
            first_free[i] = !vld_i[i] && !seen;
            seen          = seen | !vld_i[i];
        end
    end

    assign need_alloc = rec_vld_i && !(|key_hit);
    assign drop_o     = need_alloc && !(|first_free);

    for (genvar i = 0; i < N; i++) begin : g_ent
        assign val_hit[i]    = vld_i[i] && (val_i[i] == rec_old_i);
        assign key_hit[i]    = vld_i[i] && (key_i[i] == rec_old_i);
        assign alloc_here[i] = need_alloc && first_free[i];
        assign vld_o[i]      = vld_i[i] | alloc_here[i];
        assign key_o[i]      = alloc_here[i] ? rec_old_i : key_i[i];
        assign val_o[i]      = ((rec_vld_i && val_hit[i]) || alloc_here[i]) ? rec_new_i : val_i[i];
    end

endmodule

// File: rtl/eqt_lookup.sv
// Combinational resolve of one query label.
module eqt_lookup #(
    parameter int N  = 16,
    parameter int LW = 8
) (
    input  logic [N-1:0]  vld_i,
    input  logic [LW-1:0] key_i [N],
    input  logic [LW-1:0] val_i [N],
    input  logic [LW-1:0] qry_i,
    output logic [LW-1:0] res_o,
    output logic [N-1:0]  hit_o
);

    for (genvar i = 0; i < N; i++) begin : g_cmp
        assign hit_o[i] = vld_i[i] && (key_i[i] == qry_i);
    end

    always_comb begin
        logic found;
        found = 1'b0;
        res_o = qry_i;
        for (int i = 0; i < N; i++) begin
            if (hit_o[i] && (!found || val_i[i] < res_o)) begin
                res_o = val_i[i];
                found = 1'b1;
            end
        end
    end

endmodule

// File: rtl/eqt_ctrl.sv
// Occupancy state machine: empty, partly filled, full, overflowed.
module eqt_ctrl
    import eqt_pkg::*;
#(
    parameter int N = 16
) (
    input  logic         clk_i,
    input  logic         rst_ni,
    input  logic         clr_i,
    input  logic         drop_i,
    input  logic [N-1:0] vld_nxt_i,
    output logic         full_o,
    output logic         ovf_o
);

    eqt_state_e state_q, state_d;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= S_EMPTY;
        else         state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (clr_i) begin
            state_d = S_EMPTY;                   // wipe
        end else begin
            unique case (state_q)
                S_EMPTY, S_PART, S_FULL: begin
                    if (drop_i)          state_d = S_OVF;   // spill
                    else if (&vld_nxt_i) state_d = S_FULL;  // fill / top-up
                    else if (|vld_nxt_i) state_d = S_PART;  // fill
                    else                 state_d = S_EMPTY;
                end
                S_OVF:                   state_d = S_OVF;   // hold
            endcase
        end
    end

    always_comb begin
        full_o = 1'b0;
        ovf_o  = 1'b0;
        unique case (state_q)
            S_EMPTY, S_PART: ;
            S_FULL:  full_o = 1'b1;
            S_OVF: begin
                full_o = 1'b1;
                ovf_o  = 1'b1;
            end
        endcase
    end

    // R7: overflow stays raised until a clear
    p_ovf_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ovf_o && !clr_i |=> ovf_o);

    // R8: a clear drops both flags on the next cycle
    p_clear_flags_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> !full_o && !ovf_o);

endmodule

// File: rtl/label_equiv_table.sv
module label_equiv_table #(
    parameter int ENTRIES = 16,
    parameter int LW      = 8,
    parameter bit ODD_PE  = 1'b0
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          clr_i,
    input  logic          own_vld_i,
    input  logic [LW-1:0] own_old_i,
    input  logic [LW-1:0] own_new_i,
    input  logic          prv_vld_i,
    input  logic [LW-1:0] prv_old_i,
    input  logic [LW-1:0] prv_new_i,
    input  logic [LW-1:0] qry_lbl_i,
    output logic [LW-1:0] qry_res_o,
    output logic          nxt_vld_o,
    output logic [LW-1:0] nxt_old_o,
    output logic [LW-1:0] nxt_new_o,
    output logic          full_o,
    output logic          ovf_o
);

    localparam int N = ENTRIES;

    logic [N-1:0]  vld_q, vld_a, vld_b;
    logic [LW-1:0] key_q [N];
    logic [LW-1:0] val_q [N];
    logic [LW-1:0] key_a [N];
    logic [LW-1:0] val_a [N];
    logic [LW-1:0] key_b [N];
    logic [LW-1:0] val_b [N];
    logic          drop_a, drop_b;
    logic          rec2_vld;
    logic [N-1:0]  qry_hit;

    // Pairing variant: odd elements forward, even elements absorb
    if (ODD_PE) begin : g_odd
        assign rec2_vld  = 1'b0;
        assign nxt_vld_o = own_vld_i;
        assign nxt_old_o = own_old_i;
        assign nxt_new_o = own_new_i;
    end else begin : g_even
        assign rec2_vld  = prv_vld_i;
        assign nxt_vld_o = 1'b0;
        assign nxt_old_o = '0;
        assign nxt_new_o = '0;
    end

    // Own record first
    eqt_update #(.N(N), .LW(LW)) i_upd_own (
        .vld_i(vld_q), .key_i(key_q), .val_i(val_q),
        .rec_vld_i(own_vld_i), .rec_old_i(own_old_i), .rec_new_i(own_new_i),
        .vld_o(vld_a), .key_o(key_a), .val_o(val_a), .drop_o(drop_a)
    );

    // Received record second, on the result of the first
    eqt_update #(.N(N), .LW(LW)) i_upd_prv (
        .vld_i(vld_a), .key_i(key_a), .val_i(val_a),
        .rec_vld_i(rec2_vld), .rec_old_i(prv_old_i), .rec_new_i(prv_new_i),
        .vld_o(vld_b), .key_o(key_b), .val_o(val_b), .drop_o(drop_b)
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            vld_q <= '0;
            for (int i = 0; i < N; i++) begin
                key_q[i] <= '0;
                val_q[i] <= '0;
            end
        end else begin
            vld_q <= clr_i ? '0 : vld_b;
            for (int i = 0; i < N; i++) begin
                key_q[i] <= key_b[i];
                val_q[i] <= val_b[i];
            end
        end
    end

    eqt_lookup #(.N(N), .LW(LW)) i_lookup (
        .vld_i(vld_q), .key_i(key_q), .val_i(val_q),
        .qry_i(qry_lbl_i), .res_o(qry_res_o), .hit_o(qry_hit)
    );

    eqt_ctrl #(.N(N)) i_ctrl (
        .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr_i),
        .drop_i(drop_a | drop_b), .vld_nxt_i(vld_b),
        .full_o(full_o), .ovf_o(ovf_o)
    );

    // R4: a key is never stored twice
    p_unique_key_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(qry_hit));

    // R3: a label without an entry resolves to itself
    p_absent_pass_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(|qry_hit) |-> qry_res_o == qry_lbl_i);

    // R7: the full flag implies every entry is in use
    p_full_entries_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        full_o |-> &vld_q);

    // R9: a clear leaves no entry valid, whatever records came with it
    p_clear_wipes_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clr_i |=> vld_q == '0);

endmodule

// File: tb/test_label_equiv_table.sv
module test_label_equiv_table;

    localparam int CLK_PERIOD = 10;
    localparam int N  = 4;
    localparam int LW = 8;
    localparam int NV = 12;

    // {own_vld, own_old, own_new, prv_vld, prv_old, prv_new, query, expected}
    localparam logic [63:0] VEC [NV] = '{
        {8'd1, 8'd5, 8'd5, 8'd0, 8'd0, 8'd0, 8'd5, 8'd5},  // R3 absent
        {8'd1, 8'd7, 8'd7, 8'd0, 8'd0, 8'd0, 8'd5, 8'd5},  // R1 self entry
        {8'd1, 8'd7, 8'd5, 8'd0, 8'd0, 8'd0, 8'd7, 8'd7},  // R1 before merge
        {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd7, 8'd5},  // R1 merged
        {8'd1, 8'd9, 8'd9, 8'd0, 8'd0, 8'd0, 8'd9, 8'd9},  // R1 new self
        {8'd1, 8'd5, 8'd2, 8'd0, 8'd0, 8'd0, 8'd5, 8'd5},  // R2 old still visible
        {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd7, 8'd2},  // R2 alias rewritten
        {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd5, 8'd2},  // R2 key rewritten
        {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd9, 8'd9},  // R2 others untouched
        {8'd1, 8'd9, 8'd2, 8'd1, 8'd2, 8'd1, 8'd9, 8'd9},  // R5 two records
        {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd9, 8'd1},  // R5 order own first
        {8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd2, 8'd1}   // R4 allocated key
    };
    localparam string VREQ [NV] = '{"R3", "R1", "R1", "R1", "R1", "R2",
                                    "R2", "R2", "R2", "R5", "R5", "R4"};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          clr = 1'b0;
    logic          ov = 1'b0, pv = 1'b0;
    logic [LW-1:0] oo = '0, on = '0, po = '0, pn = '0, q = '0;
    logic [LW-1:0] res, n_old, n_new;
    logic          n_vld, full, ovf;

    logic          b_ov = 1'b0, b_pv = 1'b0;
    logic [LW-1:0] b_oo = '0, b_on = '0, b_po = '0, b_pn = '0, b_q = '0;
    logic [LW-1:0] b_res, b_old, b_new;
    logic          b_vld, b_full, b_ovf;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    label_equiv_table #(.ENTRIES(N), .LW(LW), .ODD_PE(1'b0)) i_label_equiv_table (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(clr),
        .own_vld_i(ov), .own_old_i(oo), .own_new_i(on),
        .prv_vld_i(pv), .prv_old_i(po), .prv_new_i(pn),
        .qry_lbl_i(q), .qry_res_o(res),
        .nxt_vld_o(n_vld), .nxt_old_o(n_old), .nxt_new_o(n_new),
        .full_o(full), .ovf_o(ovf)
    );

    label_equiv_table #(.ENTRIES(N), .LW(LW), .ODD_PE(1'b1)) i_label_equiv_table_odd (
        .clk_i(clk), .rst_ni(rst_n), .clr_i(1'b0),
        .own_vld_i(b_ov), .own_old_i(b_oo), .own_new_i(b_on),
        .prv_vld_i(b_pv), .prv_old_i(b_po), .prv_new_i(b_pn),
        .qry_lbl_i(b_q), .qry_res_o(b_res),
        .nxt_vld_o(b_vld), .nxt_old_o(b_old), .nxt_new_o(b_new),
        .full_o(b_full), .ovf_o(b_ovf)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic rec(input logic [LW-1:0] o, input logic [LW-1:0] n);
        @(negedge clk);
        ov = 1'b1; oo = o; on = n; pv = 1'b0;
        @(negedge clk);
        ov = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 5000);
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        q = 8'd42;
        #1;
        // R10 reset state
        chk("R10 full", full, 0);
        chk("R10 ovf", ovf, 0);
        chk("R10 nxt_vld", n_vld, 0);
        chk("R10 lookup", res, 42);
        rst_n = 1'b1;

        // Table walk: the query result reflects all earlier rows
        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            {ov, oo, on} = {VEC[k][56], VEC[k][55:48], VEC[k][47:40]};
            {pv, po, pn} = {VEC[k][32], VEC[k][31:24], VEC[k][23:16]};
            q = VEC[k][15:8];
            #1;
            chk($sformatf("%s row %0d", VREQ[k], k), res, VEC[k][7:0]);
            // R6: even element never forwards
            chk("R6 even nxt_vld", n_vld, 0);
        end
        @(negedge clk);
        ov = 1'b0; pv = 1'b0;
        #1;
        chk("R7 full after 4 entries", full, 1);
        chk("R7 no overflow yet", ovf, 0);

        // R7: record with an existing key needs no entry
        rec(8'd5, 8'd0);
        chk("R7 no alloc when key present", ovf, 0);

        // R7: allocation lost, rewrite still applied
        rec(8'd1, 8'd0);
        q = 8'd5;
        #1;
        chk("R7 overflow raised", ovf, 1);
        chk("R7 rewrite despite overflow", res, 0);
        rec(8'd7, 8'd7);
        chk("R7 overflow sticky", ovf, 1);

        // R8 / R9: clear with a record in the same cycle
        @(negedge clk);
        clr = 1'b1; ov = 1'b1; oo = 8'd3; on = 8'd3;
        @(negedge clk);
        clr = 1'b0; ov = 1'b0; q = 8'd5;
        #1;
        chk("R8 full cleared", full, 0);
        chk("R8 ovf cleared", ovf, 0);
        chk("R8 entries freed", res, 5);
        rec(8'd10, 8'd10);
        rec(8'd11, 8'd11);
        rec(8'd12, 8'd12);
        chk("R9 three entries not full", full, 0);
        rec(8'd13, 8'd13);
        chk("R9 fourth entry fills", full, 1);

        // R6: odd element forwards own record, ignores received one
        @(negedge clk);
        b_ov = 1'b1; b_oo = 8'd4; b_on = 8'd4;
        b_pv = 1'b1; b_po = 8'd20; b_pn = 8'd20;
        #1;
        chk("R6 odd nxt_vld", b_vld, 1);
        chk("R6 odd nxt_old", b_old, 4);
        chk("R6 odd nxt_new", b_new, 4);
        @(negedge clk);
        b_ov = 1'b0; b_pv = 1'b1; b_po = 8'd20; b_pn = 8'd1;
        #1;
        chk("R6 odd nxt idle", b_vld, 0);
        @(negedge clk);
        b_pv = 1'b0; b_q = 8'd20;
        #1;
        chk("R6 received record ignored", b_res, 20);
        chk("R6 odd table not full", b_full, 0);

        finish_run();
    end

endmodule